// File: doc/BRIEF.md
# LVDS Pixel-to-Lane Serializer

This block turns one parallel colour pixel, with its sync and enable bits, into seven-bit serial words on four data lanes and a clock lane. It runs on a fast clock. A pixel strobe loads a new pixel, and a bit enable at seven times the pixel rate steps through the seven slots of the pixel period. Pads, PLLs and differential drivers lie outside the block.

A two-bit layout select picks one of three bit-to-slot arrangements. The first is a three-lane 18-bit layout. The second is a 24-bit layout that keeps the six upper colour bits on lanes 0 to 2 and sends the two low bits on lane 3. The third is a 24-bit layout that puts the six low colour bits on lanes 0 to 2 and the two top bits on lane 3. A mirror input sends every data lane's seven slots in reverse order.

A small controller holds the sequencing. Its states are IDLE (no pixel loaded, all outputs low), RUN (slots 0 to 5) and LAST (slot 6). The transitions are: LOAD (any state to RUN on the strobe), STEP (RUN to RUN, or RUN to LAST after slot 5, on a bit enable), STARVE (LAST to IDLE on a bit enable without a strobe) and HOLD (no change when neither input is high).

Top module: `lvds_pixel_serializer`

## Requirements
- R1: After reset and while IDLE, every data lane output and the clock lane output are 0.
- R2: On a clock edge with `pix_stb` high, the pixel is captured, and slot 0 is on the outputs in the following cycle. Each later edge with `bit_en` high (and `pix_stb` low) moves to the next slot. An edge with both low leaves all outputs unchanged.
- R3: Layout codes 0 and 3 select the 18-bit layout. Using the colour inputs' bits [7:2], lane 0 slots 0..6 carry g2,r7,r6,r5,r4,r3,r2. Lane 1 carries b3,b2,g7,g6,g5,g4,g3. Lane 2 carries de,vsync,hsync,b7,b6,b5,b4. Lane 3 stays 0, and colour bits [1:0] have no effect.
- R4: Layout code 1 gives lanes 0..2 exactly as in R3. Lane 3 slots 0..6 carry spare,b1,b0,g1,g0,r1,r0.
- R5: Layout code 2 gives lanes 0..2 the R3 pattern built on bits [5:0], so lane 0 is g0,r5..r0, lane 1 is b1,b0,g5..g1, and lane 2 is de,vsync,hsync,b5..b2. Lane 3 carries spare,b7,b6,g7,g6,r7,r6.
- R6: The control bits sit at fixed slots: hsync in lane 2 slot 2, vsync in lane 2 slot 1, de in lane 2 slot 0, and the spare bit in lane 3 slot 0 (layouts 1 and 2 only).
- R7: With `mirror` high at the strobe, each data lane sends its slot 6 bit first and its slot 0 bit last.
- R8: The clock lane shows 1,1,0,0,0,1,1 over slots 0..6 in every layout, whatever `mirror` is.
- R9: Layout select, mirror, colour and control inputs are sampled only at the strobe. Changes between strobes leave the current period unchanged.
- R10: A `bit_en` in slot 6 without a strobe sends the block to IDLE, and all outputs go to 0 in the next cycle.
- R11: A strobe in the middle of a period takes priority over shifting. The new pixel's slot 0 appears in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_stb | input | 1 | Pixel strobe: load a new pixel |
| bit_en | input | 1 | Slot advance enable |
| lane_fmt | input | 2 | Layout select (0,3: 18-bit; 1: 24-bit upper-first; 2: 24-bit lower-first) |
| mirror | input | 1 | Reverse slot order on data lanes |
| red | input | 8 | Red component |
| grn | input | 8 | Green component |
| blu | input | 8 | Blue component |
| hsync | input | 1 | Horizontal sync |
| vsync | input | 1 | Vertical sync |
| de | input | 1 | Data enable |
| spare | input | 1 | Spare control bit |
| lane_out | output | 4 | Serial data bit for each lane |
| clk_lane_out | output | 1 | Serial clock-lane bit |

## Verification
If the slot counter is off by one against the shifters, the clock-lane pattern drifts against the data at the first shifted slot of the period. A wrong controller state shows within one cycle as outputs that do not drop after a starve, or as slot 0 missing after a strobe. A wrong slot mapping or reversal shows as a wrong bit on a specific lane and slot within seven cycles of the strobe. The bench compares every output bit in every slot against a model built from the requirements, so such faults appear in the same cycle they occur.

// File: rtl/lvds_ser_pkg.sv
package lvds_ser_pkg;

    localparam int SLOTS      = 7;
    localparam int SLOT_W     = $clog2(SLOTS);
    localparam int COLOR_W    = 8;
    localparam int DATA_LANES = 4;
    localparam int BASE_LANES = 3;

    typedef logic [SLOTS-1:0] slot_word_t;

    typedef enum logic [1:0] {
        FMT_18B       = 2'd0,
        FMT_24B_UPPER = 2'd1,
        FMT_24B_LOWER = 2'd2,
        FMT_RESERVED  = 2'd3
    } lane_fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_LAST = 2'd2
    } ser_state_e;

    // Clock lane pattern: bit k goes out in slot k (1,1,0,0,0,1,1).
    localparam slot_word_t CLK_LANE_WORD = 7'b1100011;

    function automatic slot_word_t flip_slots(input slot_word_t w);
        slot_word_t r;
        for (int i = 0; i < SLOTS; i++) begin
            r[i] = w[SLOTS-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/lvds_slot_mapper.sv
module lvds_slot_mapper
    import lvds_ser_pkg::*;
(
    input  logic [1:0]                       lane_fmt,
    input  logic                             mirror,
    input  logic [COLOR_W-1:0]               red,
    input  logic [COLOR_W-1:0]               grn,
    input  logic [COLOR_W-1:0]               blu,
    input  logic                             hsync,
    input  logic                             vsync,
    input  logic                             de,
    input  logic                             spare,
    output logic [DATA_LANES-1:0][SLOTS-1:0] lane_words
);

    localparam int SIX = 6;

    lane_fmt_e                         fmt;
    logic [SIX-1:0]                    r6, g6, b6;
    logic [DATA_LANES-1:0][SLOTS-1:0]  plain;

    assign fmt = lane_fmt_e'(lane_fmt);

    // Six colour bits that feed lanes 0..2.
    always_comb begin
        unique case (fmt)
            FMT_24B_LOWER: begin
                r6 = red[SIX-1:0];
                g6 = grn[SIX-1:0];
                b6 = blu[SIX-1:0];
            end
            default: begin
                r6 = red[COLOR_W-1 -: SIX];
                g6 = grn[COLOR_W-1 -: SIX];
                b6 = blu[COLOR_W-1 -: SIX];
            end
        endcase
    end

    // Words are written {slot6 .. slot0}.
    always_comb begin
        plain[0] = {r6[0], r6[1], r6[2], r6[3], r6[4], r6[5], g6[0]};
        plain[1] = {g6[1], g6[2], g6[3], g6[4], g6[5], b6[0], b6[1]};
        plain[2] = {b6[2], b6[3], b6[4], b6[5], hsync, vsync, de};
        unique case (fmt)
            FMT_24B_UPPER: plain[3] = {red[0], red[1], grn[0], grn[1],
                                       blu[0], blu[1], spare};
            FMT_24B_LOWER: plain[3] = {red[6], red[7], grn[6], grn[7],
                                       blu[6], blu[7], spare};
            default:       plain[3] = '0;
        endcase
    end

    for (genvar l = 0; l < DATA_LANES; l++) begin : g_orient
        assign lane_words[l] = mirror ? flip_slots(plain[l]) : plain[l];
    end

endmodule

// File: rtl/lvds_ser_ctrl.sv
module lvds_ser_ctrl
    import lvds_ser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_stb,
    input  logic              bit_en,
    output logic              load,
    output logic              shift,
    output logic              clear,
    output logic              running,
    output logic [SLOT_W-1:0] slot_idx
);

    localparam logic [SLOT_W-1:0] SLOT_PENULT = SLOT_W'(SLOTS-2);

    ser_state_e        state, state_nxt;
    logic [SLOT_W-1:0] slot_nxt;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            slot_idx <= '0;
        end else begin
            state    <= state_nxt;
            slot_idx <= slot_nxt;
        end
    end

    // Transitions: LOAD, STEP, STARVE, HOLD
    always_comb begin
        state_nxt = state;
        slot_nxt  = slot_idx;
        if (pix_stb) begin
            state_nxt = ST_RUN;
            slot_nxt  = '0;
        end else if (bit_en) begin
            unique case (state)
                ST_IDLE: begin
                    state_nxt = ST_IDLE;
                    slot_nxt  = '0;
                end
                ST_RUN: begin
                    slot_nxt  = slot_idx + 1'b1;
                    state_nxt = (slot_idx == SLOT_PENULT) ? ST_LAST : ST_RUN;
                end
                ST_LAST: begin
                    state_nxt = ST_IDLE;
                    slot_nxt  = '0;
                end
                default: begin
                    state_nxt = ST_IDLE;
                    slot_nxt  = '0;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        load    = pix_stb;
        shift   = 1'b0;
        clear   = 1'b0;
        running = 1'b0;
        unique case (state)
            ST_IDLE: running = 1'b0;
            ST_RUN: begin
                running = 1'b1;
                shift   = !pix_stb && bit_en;
            end
            ST_LAST: begin
                running = 1'b1;
                clear   = !pix_stb && bit_en;
            end
            default: running = 1'b0;
        endcase
    end

endmodule

// File: rtl/lvds_lane_shifter.sv
module lvds_lane_shifter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         clear,
    input  logic [W-1:0] word,
    output logic         sout
);

    logic [W-1:0] sh;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= word;
        end else if (clear) begin
            sh <= '0;
        end else if (shift) begin
            sh <= {1'b0, sh[W-1:1]};
        end
    end

    assign sout = sh[0];

endmodule

// File: rtl/lvds_pixel_serializer.sv
module lvds_pixel_serializer
    import lvds_ser_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pix_stb,
    input  logic                  bit_en,
    input  logic [1:0]            lane_fmt,
    input  logic                  mirror,
    input  logic [COLOR_W-1:0]    red,
    input  logic [COLOR_W-1:0]    grn,
    input  logic [COLOR_W-1:0]    blu,
    input  logic                  hsync,
    input  logic                  vsync,
    input  logic                  de,
    input  logic                  spare,
    output logic [DATA_LANES-1:0] lane_out,
    output logic                  clk_lane_out
);

    logic                             load, shift, clear, running;
    logic [SLOT_W-1:0]                slot_idx;
    logic [DATA_LANES-1:0][SLOTS-1:0] lane_words;

    lvds_slot_mapper u_map (
        .lane_fmt   (lane_fmt),
        .mirror     (mirror),
        .red        (red),
        .grn        (grn),
        .blu        (blu),
        .hsync      (hsync),
        .vsync      (vsync),
        .de         (de),
        .spare      (spare),
        .lane_words (lane_words)
    );

    lvds_ser_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .pix_stb  (pix_stb),
        .bit_en   (bit_en),
        .load     (load),
        .shift    (shift),
        .clear    (clear),
        .running  (running),
        .slot_idx (slot_idx)
    );

    for (genvar l = 0; l < DATA_LANES; l++) begin : g_lane
        lvds_lane_shifter #(.W(SLOTS)) u_sh (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load),
            .shift (shift),
            .clear (clear),
            .word  (lane_words[l]),
            .sout  (lane_out[l])
        );
    end

    lvds_lane_shifter #(.W(SLOTS)) u_clk_sh (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .shift (shift),
        .clear (clear),
        .word  (CLK_LANE_WORD),
        .sout  (clk_lane_out)
    );

endmodule

// File: rtl/lvds_ser_checker.sv
module lvds_ser_checker
    import lvds_ser_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  pix_stb,
    input logic                  bit_en,
    input logic [1:0]            lane_fmt,
    input logic [DATA_LANES-1:0] lane_out,
    input logic                  clk_lane_out,
    input logic                  running,
    input logic [SLOT_W-1:0]     slot_idx
);

    localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(SLOTS-1);

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> (lane_out == '0 && !clk_lane_out));

    assert_load_slot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_stb |=> (running && slot_idx == '0 && clk_lane_out));

    assert_hold_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!pix_stb && !bit_en) |=> ($stable(lane_out) && $stable(clk_lane_out)));

    assert_lane3_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_stb && (lane_fmt == 2'd0 || lane_fmt == 2'd3)) |=> !lane_out[3]);

    assert_clk_pattern_R8: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> (clk_lane_out == CLK_LANE_WORD[slot_idx]));

    assert_starve_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (running && slot_idx == SLOT_END && bit_en && !pix_stb)
        |=> (!running && lane_out == '0 && !clk_lane_out));

endmodule

bind lvds_pixel_serializer lvds_ser_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .pix_stb      (pix_stb),
    .bit_en       (bit_en),
    .lane_fmt     (lane_fmt),
    .lane_out     (lane_out),
    .clk_lane_out (clk_lane_out),
    .running      (running),
    .slot_idx     (slot_idx)
);

// File: tb/lvds_pixel_serializer_tb.sv
`timescale 1ns/1ps
module lvds_pixel_serializer_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pix_stb = 1'b0;
    logic       bit_en = 1'b0;
    logic [1:0] lane_fmt = 2'd0;
    logic       mirror = 1'b0;
    logic [7:0] red = 8'd0, grn = 8'd0, blu = 8'd0;
    logic       hsync = 1'b0, vsync = 1'b0, de = 1'b0, spare = 1'b0;
    logic [3:0] lane_out;
    logic       clk_lane_out;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    int         q_due[$];
    logic [4:0] q_val[$];
    string      q_tag[$];
    logic [4:0] last_val = 5'd0;

    always #4 clk = ~clk;

    lvds_pixel_serializer u_dut (
        .clk(clk), .rst_n(rst_n), .pix_stb(pix_stb), .bit_en(bit_en),
        .lane_fmt(lane_fmt), .mirror(mirror), .red(red), .grn(grn), .blu(blu),
        .hsync(hsync), .vsync(vsync), .de(de), .spare(spare),
        .lane_out(lane_out), .clk_lane_out(clk_lane_out)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Model from the requirements: bit on lane l in transmitted position k.
    function automatic logic exp_lane(input logic [1:0] f, input logic m,
                                      input int l, input int k,
                                      input logic [7:0] r, input logic [7:0] g,
                                      input logic [7:0] b, input logic h,
                                      input logic v, input logic d,
                                      input logic sp);
        int s = m ? 6 - k : k;
        int o = (f == 2'd2) ? 0 : 2;
        case (l)
            0: return (s == 0) ? g[o] : r[o+6-s];
            1: return (s == 0) ? b[o+1] : (s == 1) ? b[o] : g[o+7-s];
            2: return (s == 0) ? d : (s == 1) ? v : (s == 2) ? h : b[o+8-s];
            default: begin
                if (f == 2'd1) begin
                    case (s)
                        0: return sp;
                        1: return b[1];
                        2: return b[0];
                        3: return g[1];
                        4: return g[0];
                        5: return r[1];
                        default: return r[0];
                    endcase
                end else if (f == 2'd2) begin
                    case (s)
                        0: return sp;
                        1: return b[7];
                        2: return b[6];
                        3: return g[7];
                        4: return g[6];
                        5: return r[7];
                        default: return r[6];
                    endcase
                end
                return 1'b0;
            end
        endcase
    endfunction

    task automatic push(input logic [4:0] v, input string tag);
        q_due.push_back(cyc + 1);
        q_val.push_back(v);
        q_tag.push_back(tag);
        last_val = v;
    endtask

    task automatic check_now(input logic [4:0] exp, input string tag);
        logic [4:0] got = {clk_lane_out, lane_out};
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    // Monitor: compare each item in the cycle it is due.
    always @(negedge clk) begin
        while (q_due.size() > 0 && q_due[0] == cyc) begin
            check_now(q_val[0], q_tag[0]);
            void'(q_due.pop_front());
            void'(q_val.pop_front());
            void'(q_tag.pop_front());
        end
    end

    task automatic send_pixel(input logic [1:0] f, input logic m,
                              input logic [7:0] r, input logic [7:0] g,
                              input logic [7:0] b, input logic h, input logic v,
                              input logic d, input logic sp, input string tag,
                              input int n_slots, input int stall_at,
                              input bit scramble);
        for (int k = 0; k < n_slots; k++) begin
            logic [4:0] e;
            if (k == 0) begin
                lane_fmt = f; mirror = m; red = r; grn = g; blu = b;
                hsync = h; vsync = v; de = d; spare = sp;
                pix_stb = 1'b1;
            end else begin
                pix_stb = 1'b0;
                if (scramble) begin
                    lane_fmt = ~f; mirror = ~m; red = ~r; grn = ~g; blu = ~b;
                    hsync = ~h; vsync = ~v; de = ~d; spare = ~sp;
                end
            end
            bit_en = 1'b1;
            for (int l = 0; l < 4; l++) e[l] = exp_lane(f, m, l, k, r, g, b, h, v, d, sp);
            e[4] = (k < 2 || k > 4);
            push(e, tag);
            @(negedge clk);
            if (k == stall_at) begin
                pix_stb = 1'b0;
                bit_en  = 1'b0;
                push(last_val, "R2 hold");
                @(negedge clk);
            end
        end
    endtask

    task automatic idle(input int n, input logic en, input string tag);
        for (int i = 0; i < n; i++) begin
            pix_stb = 1'b0;
            bit_en  = en;
            push(en ? 5'd0 : last_val, tag);
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        check_now(5'd0, "R1 reset");
        rst_n = 1'b1;
        idle(2, 1'b1, "R1 idle");
        check_now(5'd0, "R1 idle after reset");

        send_pixel(2'd0, 1'b0, 8'hA5, 8'h3C, 8'hF0, 1, 0, 1, 1, "R3", 7, -1, 0);
        send_pixel(2'd0, 1'b0, 8'hA6, 8'h3F, 8'hF3, 1, 0, 1, 1, "R3 lsb", 7, -1, 0);
        send_pixel(2'd1, 1'b0, 8'h96, 8'h69, 8'hC3, 0, 1, 0, 1, "R4", 7, -1, 0);
        send_pixel(2'd2, 1'b0, 8'h5A, 8'hE1, 8'h1E, 1, 1, 0, 1, "R5", 7, -1, 0);
        send_pixel(2'd3, 1'b0, 8'h3C, 8'hC3, 8'h99, 0, 0, 1, 1, "R3 reserved", 7, -1, 0);
        send_pixel(2'd1, 1'b0, 8'h00, 8'h00, 8'h00, 1, 0, 0, 0, "R6", 7, -1, 0);
        send_pixel(2'd2, 1'b0, 8'hFF, 8'hFF, 8'hFF, 0, 1, 1, 1, "R6", 7, -1, 0);
        send_pixel(2'd1, 1'b1, 8'h96, 8'h69, 8'hC3, 0, 1, 0, 1, "R7 R8", 7, -1, 0);
        send_pixel(2'd2, 1'b1, 8'h5A, 8'hE1, 8'h1E, 1, 0, 1, 0, "R7 R8", 7, -1, 0);
        send_pixel(2'd0, 1'b1, 8'hC6, 8'h39, 8'h81, 1, 1, 1, 0, "R7", 7, -1, 0);
        send_pixel(2'd2, 1'b0, 8'h4B, 8'hB4, 8'h2D, 1, 0, 1, 1, "R9", 7, -1, 1);
        send_pixel(2'd1, 1'b1, 8'h87, 8'h78, 8'h0F, 0, 1, 1, 0, "R9", 7, -1, 1);
        send_pixel(2'd1, 1'b0, 8'h12, 8'h34, 8'h56, 1, 1, 0, 1, "R2", 7, 3, 0);
        send_pixel(2'd2, 1'b0, 8'hF0, 8'h0F, 8'hAA, 0, 0, 1, 1, "R11", 4, -1, 0);
        send_pixel(2'd1, 1'b1, 8'h55, 8'hAA, 8'h33, 1, 0, 1, 0, "R11", 7, 6, 0);
        idle(3, 1'b1, "R10 starve");
        idle(2, 1'b0, "R1 hold idle");
        send_pixel(2'd0, 1'b0, 8'hE7, 8'h18, 8'h66, 0, 1, 1, 0, "R2", 7, 0, 0);
        idle(2, 1'b1, "R10 starve");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule